// File: doc/BRIEF.md
# Resistive Cell Program-Verify Controller

This block steers the write-tuning of a single resistive memory cell until the current read back from it sits close to a requested value. It sends reset pulses, set pulses and verify reads to an analog array through request/acknowledge pairs. It receives the measured current as a digital code and compares that code with a target code captured at start. Every iteration is a reset, then a set, then a verify read. The measured code decides whether the loop stops or runs again.

Tuning runs in two phases. In the coarse phase the set compliance level goes up one step on each iteration. The level that first brings the cell within a wide tolerance is kept. In the fine phase the kept level is replayed unchanged. Convergence then depends on the random spread of the cell from one cycle to the next, and the loop stops when the cell falls within a narrow tolerance. Each phase has an iteration budget that software sets. Running out of budget, or reaching the highest compliance level without success, ends the run with a failure flag.

Top module: `cell_tune_ctrl`

## Requirements
- R1: Each iteration issues exactly the sequence reset pulse, set pulse, verify read, and never asserts more than one of `pulse_reset_o`, `pulse_set_o`, `read_req_o` at a time.
- R2: An asserted command stays asserted until `array_ack_i` is sampled high. The controller moves to the next command on the clock edge where the acknowledge is seen, and `meas_i` is taken on the edge that acknowledges the read.
- R3: The deviation is |target − measured|. The coarse phase is satisfied when 10·deviation < 3·target, a strict comparison, so 30% exactly does not pass.
- R4: Start sets `set_level_o` to 0. Each coarse iteration that fails its tolerance, and is not the last one allowed, raises `set_level_o` by exactly one.
- R5: When the coarse tolerance is met, the current level is kept. Every fine-phase set pulse uses that level, and `set_level_o` does not change until the next start.
- R6: The fine phase is satisfied when 10·deviation < target, a strict comparison. The controller then returns to idle with `done_o` high, and `done_o` stays high until the next accepted start.
- R7: A coarse iteration that fails its tolerance while `set_level_o` is at its highest value (all ones) ends the run. `fail_o` goes high and the controller returns to idle.
- R8: The coarse and fine phases each run at most max(limit, 1) iterations, with the limits taken from `coarse_max_i` and `fine_max_i`. The fine count begins at zero when the fine phase is entered. Using up the budget ends the run with `fail_o` high, and `fail_o` stays high until the next accepted start.
- R9: `start_i` is accepted only while `busy_o` is low, and `target_i` is captured at that moment. A start while busy has no effect on the commands, the levels or the outcome of the run in progress.
- R10: After reset, `busy_o`, `done_o`, `fail_o` and all commands are low and `set_level_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a tuning run (accepted when idle) |
| target_i | input | CW | Target current code, captured at start |
| coarse_max_i | input | IW | Coarse-phase iteration budget |
| fine_max_i | input | IW | Fine-phase iteration budget |
| array_ack_i | input | 1 | Acknowledge of the current command from the array |
| meas_i | input | CW | Measured current code, valid with the read acknowledge |
| pulse_reset_o | output | 1 | Reset pulse request |
| pulse_set_o | output | 1 | Set pulse request |
| read_req_o | output | 1 | Verify read request |
| set_level_o | output | LW | Compliance level applied to set pulses |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | Last run converged |
| fail_o | output | 1 | Last run gave up |

## Verification
A command becomes visible in the cycle after the edge that accepts the start, or after the edge that acknowledges the previous command. The bench's array model therefore samples commands and drives `array_ack_i` and `meas_i` on falling edges, with a random wait of zero to three cycles. A verdict takes one evaluation cycle after the read acknowledge. `done_o` or `fail_o` then rises on the edge that follows, so the bench waits on falling edges until one of them is high before it compares the outcome, the read count and the final level against its own replay of the algorithm. The level applied to each set pulse is compared at the moment that pulse is acknowledged.

// File: rtl/cell_tune_pkg.sv
package cell_tune_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RESET,
    ST_SET,
    ST_READ,
    ST_EVAL
  } tune_state_e;

  // Magnitude of the difference between two codes.
  function automatic int unsigned abs_gap(int unsigned a, int unsigned b);
    return (a >= b) ? (a - b) : (b - a);
  endfunction

  // Wide window: gap below 30% of target.
  function automatic logic within_wide(int unsigned gap, int unsigned tgt);
    return (10 * gap) < (3 * tgt);
  endfunction

  // Narrow window: gap below 10% of target.
  function automatic logic within_narrow(int unsigned gap, int unsigned tgt);
    return (10 * gap) < tgt;
  endfunction

endpackage

// File: rtl/cell_tune_judge.sv
module cell_tune_judge
  import cell_tune_pkg::*;
#(
  parameter int CW = 10
) (
  input  logic [CW-1:0] target_i,
  input  logic [CW-1:0] meas_i,
  output logic          wide_ok_o,
  output logic          narrow_ok_o
);

  int unsigned gap_u;

  always_comb begin
    gap_u       = abs_gap(32'(target_i), 32'(meas_i));
    wide_ok_o   = within_wide(gap_u, 32'(target_i));
    narrow_ok_o = within_narrow(gap_u, 32'(target_i));
  end

endmodule

// File: rtl/cell_tune_tracker.sv
module cell_tune_tracker #(
  parameter int LW = 4,
  parameter int IW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart_i,
  input  logic          level_up_i,
  input  logic          iter_clr_i,
  input  logic          iter_up_i,
  output logic [LW-1:0] level_o,
  output logic [IW-1:0] iter_o,
  output logic          level_top_o
);

  localparam logic [LW-1:0] LEVEL_TOP = '1;

  logic [LW-1:0] level_q;
  logic [IW-1:0] iter_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= '0;
    end else if (restart_i) begin
      level_q <= '0;
    end else if (level_up_i) begin
      level_q <= level_q + LW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iter_q <= '0;
    end else if (iter_clr_i) begin
      iter_q <= '0;
    end else if (iter_up_i) begin
      iter_q <= iter_q + IW'(1);
    end
  end

  assign level_o     = level_q;
  assign iter_o      = iter_q;
  assign level_top_o = (level_q == LEVEL_TOP);

endmodule

// File: rtl/cell_tune_fsm.sv
module cell_tune_fsm
  import cell_tune_pkg::*;
#(
  parameter int IW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          ack_i,
  input  logic          wide_ok_i,
  input  logic          narrow_ok_i,
  input  logic          level_top_i,
  input  logic [IW-1:0] iter_i,
  input  logic [IW-1:0] coarse_max_i,
  input  logic [IW-1:0] fine_max_i,
  output logic          pulse_reset_o,
  output logic          pulse_set_o,
  output logic          read_req_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          fail_o,
  output logic          fine_o,
  output logic          ev_accept_o,
  output logic          ev_capture_o,
  output logic          ev_coarse_pass_o,
  output logic          ev_fine_pass_o,
  output logic          ev_retry_o,
  output logic          ev_give_up_o
);

  tune_state_e st_q, st_d;
  logic        fine_q, done_q, fail_q;
  logic        in_eval, last_try;
  logic [IW:0] used_w, limit_w;

  assign in_eval = (st_q == ST_EVAL);
  assign limit_w = fine_q ? {1'b0, fine_max_i} : {1'b0, coarse_max_i};
  assign used_w  = {1'b0, iter_i} + (IW+1)'(1);
  assign last_try = (used_w >= limit_w);

  assign ev_accept_o      = start_i && (st_q == ST_IDLE);
  assign ev_capture_o     = (st_q == ST_READ) && ack_i;
  assign ev_coarse_pass_o = in_eval && !fine_q && wide_ok_i;
  assign ev_fine_pass_o   = in_eval && fine_q && narrow_ok_i;
  assign ev_give_up_o     = in_eval && !ev_coarse_pass_o && !ev_fine_pass_o &&
                            (last_try || (!fine_q && level_top_i));
  assign ev_retry_o       = in_eval && !ev_coarse_pass_o && !ev_fine_pass_o &&
                            !ev_give_up_o;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (start_i) st_d = ST_RESET;
      ST_RESET: if (ack_i)   st_d = ST_SET;
      ST_SET:   if (ack_i)   st_d = ST_READ;
      ST_READ:  if (ack_i)   st_d = ST_EVAL;
      ST_EVAL:  st_d = (ev_fine_pass_o || ev_give_up_o) ? ST_IDLE : ST_RESET;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      fine_q <= 1'b0;
      done_q <= 1'b0;
      fail_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (ev_accept_o) begin
        fine_q <= 1'b0;
        done_q <= 1'b0;
        fail_q <= 1'b0;
      end else begin
        if (ev_coarse_pass_o) fine_q <= 1'b1;
        if (ev_fine_pass_o)   done_q <= 1'b1;
        if (ev_give_up_o)     fail_q <= 1'b1;
      end
    end
  end

  assign pulse_reset_o = (st_q == ST_RESET);
  assign pulse_set_o   = (st_q == ST_SET);
  assign read_req_o    = (st_q == ST_READ);
  assign busy_o        = (st_q != ST_IDLE);
  assign done_o        = done_q;
  assign fail_o        = fail_q;
  assign fine_o        = fine_q;

endmodule

// File: rtl/cell_tune_ctrl.sv
module cell_tune_ctrl #(
  parameter int CW = 10,
  parameter int LW = 4,
  parameter int IW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [CW-1:0] target_i,
  input  logic [IW-1:0] coarse_max_i,
  input  logic [IW-1:0] fine_max_i,
  input  logic          array_ack_i,
  input  logic [CW-1:0] meas_i,
  output logic          pulse_reset_o,
  output logic          pulse_set_o,
  output logic          read_req_o,
  output logic [LW-1:0] set_level_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          fail_o
);

  logic [CW-1:0] target_q, meas_q;
  logic          wide_ok, narrow_ok;
  logic          level_top;
  logic [IW-1:0] iter_cnt;
  logic          fine_q;
  logic          ev_accept, ev_capture, ev_coarse_pass, ev_fine_pass;
  logic          ev_retry, ev_give_up, ev_coarse_retry;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      target_q <= '0;
      meas_q   <= '0;
    end else begin
      if (ev_accept)  target_q <= target_i;
      if (ev_capture) meas_q   <= meas_i;
    end
  end

  cell_tune_judge #(.CW(CW)) u_judge (
    .target_i    (target_q),
    .meas_i      (meas_q),
    .wide_ok_o   (wide_ok),
    .narrow_ok_o (narrow_ok)
  );

  assign ev_coarse_retry = ev_retry && !fine_q;

  cell_tune_tracker #(.LW(LW), .IW(IW)) u_track (
    .clk         (clk),
    .rst_n       (rst_n),
    .restart_i   (ev_accept),
    .level_up_i  (ev_coarse_retry),
    .iter_clr_i  (ev_accept || ev_coarse_pass),
    .iter_up_i   (ev_retry),
    .level_o     (set_level_o),
    .iter_o      (iter_cnt),
    .level_top_o (level_top)
  );

  cell_tune_fsm #(.IW(IW)) u_fsm (
    .clk              (clk),
    .rst_n            (rst_n),
    .start_i          (start_i),
    .ack_i            (array_ack_i),
    .wide_ok_i        (wide_ok),
    .narrow_ok_i      (narrow_ok),
    .level_top_i      (level_top),
    .iter_i           (iter_cnt),
    .coarse_max_i     (coarse_max_i),
    .fine_max_i       (fine_max_i),
    .pulse_reset_o    (pulse_reset_o),
    .pulse_set_o      (pulse_set_o),
    .read_req_o       (read_req_o),
    .busy_o           (busy_o),
    .done_o           (done_o),
    .fail_o           (fail_o),
    .fine_o           (fine_q),
    .ev_accept_o      (ev_accept),
    .ev_capture_o     (ev_capture),
    .ev_coarse_pass_o (ev_coarse_pass),
    .ev_fine_pass_o   (ev_fine_pass),
    .ev_retry_o       (ev_retry),
    .ev_give_up_o     (ev_give_up)
  );

endmodule

// File: rtl/cell_tune_checker.sv
module cell_tune_checker #(
  parameter int LW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          array_ack_i,
  input logic          pulse_reset_o,
  input logic          pulse_set_o,
  input logic          read_req_o,
  input logic [LW-1:0] set_level_o,
  input logic          busy_o,
  input logic          done_o,
  input logic          fail_o,
  input logic          fine_q,
  input logic          level_top,
  input logic          ev_coarse_retry,
  input logic          ev_give_up
);

  p_one_cmd_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pulse_reset_o, pulse_set_o, read_req_o}));

  p_reset_then_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_reset_o && array_ack_i) |=> pulse_set_o);

  p_set_then_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_set_o && array_ack_i) |=> read_req_o);

  p_hold_reset_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_reset_o && !array_ack_i) |=> pulse_reset_o);

  p_hold_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_set_o && !array_ack_i) |=> pulse_set_o);

  p_hold_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (read_req_o && !array_ack_i) |=> read_req_o);

  p_coarse_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_coarse_retry |=> (set_level_o == LW'($past(set_level_o) + 1'b1)));

  p_start_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> (busy_o && set_level_o == '0));

  p_fine_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && fine_q) |=> (!busy_o || $stable(set_level_o)));

  p_excl_verdict_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && fail_o));

  p_top_fail_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_give_up && !fine_q && level_top) |=> (fail_o && !busy_o));

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !(pulse_reset_o || pulse_set_o || read_req_o));

endmodule

bind cell_tune_ctrl cell_tune_checker #(.LW(LW)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .start_i         (start_i),
  .array_ack_i     (array_ack_i),
  .pulse_reset_o   (pulse_reset_o),
  .pulse_set_o     (pulse_set_o),
  .read_req_o      (read_req_o),
  .set_level_o     (set_level_o),
  .busy_o          (busy_o),
  .done_o          (done_o),
  .fail_o          (fail_o),
  .fine_q          (fine_q),
  .level_top       (level_top),
  .ev_coarse_retry (ev_coarse_retry),
  .ev_give_up      (ev_give_up)
);

// File: tb/cell_tune_ctrl_bench.sv
module cell_tune_ctrl_bench;

  localparam int CW = 10;
  localparam int LW = 4;
  localparam int IW = 6;
  localparam int TOP_LVL = (1 << LW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [CW-1:0] target_i = '0;
  logic [IW-1:0] coarse_max_i = '0;
  logic [IW-1:0] fine_max_i = '0;
  logic          array_ack_i = 1'b0;
  logic [CW-1:0] meas_i = '0;
  logic          pulse_reset_o, pulse_set_o, read_req_o;
  logic [LW-1:0] set_level_o;
  logic          busy_o, done_o, fail_o;

  always #5 clk = ~clk;

  cell_tune_ctrl #(.CW(CW), .LW(LW), .IW(IW)) u_cell_tune_ctrl (
    .clk (clk), .rst_n (rst_n), .start_i (start_i), .target_i (target_i),
    .coarse_max_i (coarse_max_i), .fine_max_i (fine_max_i),
    .array_ack_i (array_ack_i), .meas_i (meas_i),
    .pulse_reset_o (pulse_reset_o), .pulse_set_o (pulse_set_o),
    .read_req_o (read_req_o), .set_level_o (set_level_o),
    .busy_o (busy_o), .done_o (done_o), .fail_o (fail_o)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Cell model: code = base + slope*level + noise[k]
  int base = 0;
  int slope = 0;
  int noise [0:127];
  int exp_lvl [0:127];
  int rd_k = 0;
  int set_k = 0;
  int next_cmd = 0;
  int last_code = 3;
  int ack_wait = 0;

  function automatic int cell_code(int lvl, int k);
    int v;
    v = base + slope * lvl + noise[k & 127];
    if (v < 0) v = 0;
    if (v > 1023) v = 1023;
    return v;
  endfunction

  // Independent replay of the tuning rules.
  task automatic predict(input int tgt, input int cmax, input int fmax,
                         output bit ok, output int reads, output int lvl_end);
    int lvl, cnt, k, m, dev, cl, fl;
    bit fine;
    lvl = 0; cnt = 0; k = 0; fine = 0; ok = 0;
    cl = (cmax < 1) ? 1 : cmax;
    fl = (fmax < 1) ? 1 : fmax;
    for (int guard = 0; guard < 120; guard++) begin
      exp_lvl[k] = lvl;
      m = cell_code(lvl, k);
      k++;
      dev = (tgt > m) ? tgt - m : m - tgt;
      if (!fine) begin
        if (dev * 10 < tgt * 3) begin
          fine = 1; cnt = 0;
        end else if (lvl == TOP_LVL || cnt + 1 >= cl) begin
          break;
        end else begin
          lvl++; cnt++;
        end
      end else begin
        if (dev * 10 < tgt) begin
          ok = 1; break;
        end else if (cnt + 1 >= fl) begin
          break;
        end else begin
          cnt++;
        end
      end
    end
    reads = k;
    lvl_end = lvl;
  endtask

  // Array model: answers commands after a random wait.
  always @(negedge clk) begin
    int code;
    code = pulse_reset_o ? 0 : pulse_set_o ? 1 : read_req_o ? 2 : 3;
    if (!rst_n) begin
      array_ack_i = 1'b0;
      last_code = 3;
    end else if (array_ack_i) begin
      array_ack_i = 1'b0;
      ack_wait = $urandom_range(0, 3);
      last_code = 3;
    end else if (code != 3) begin
      if (last_code != 3)
        chk(code == last_code, "R2", "command dropped before ack", code, last_code);
      last_code = code;
      if (ack_wait == 0) begin
        chk(code == next_cmd, "R1", "command order", code, next_cmd);
        next_cmd = (next_cmd + 1) % 3;
        if (code == 1) begin
          chk(int'(set_level_o) == exp_lvl[set_k & 127], "R4/R5", "set level",
              int'(set_level_o), exp_lvl[set_k & 127]);
          set_k++;
        end
        if (code == 2) begin
          meas_i = CW'(cell_code(int'(set_level_o), rd_k));
          rd_k++;
        end
        array_ack_i = 1'b1;
      end else begin
        ack_wait--;
      end
    end
  end

  task automatic run_case(string tag, int tgt, int cmax, int fmax, bit inject);
    bit e_ok;
    int e_reads, e_lvl;
    rd_k = 0; set_k = 0; next_cmd = 0;
    predict(tgt, cmax, fmax, e_ok, e_reads, e_lvl);
    @(negedge clk);
    target_i = CW'(tgt); coarse_max_i = IW'(cmax); fine_max_i = IW'(fmax);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o && !done_o && !fail_o, "R9", {tag, " busy after start"}, int'(busy_o), 1);
    if (inject) begin
      repeat (5) @(negedge clk);
      target_i = CW'(tgt ^ 'h155);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    while (!(done_o || fail_o) && !finished) @(negedge clk);
    chk(done_o == e_ok, "R6/R8", {tag, " verdict done"}, int'(done_o), int'(e_ok));
    chk(fail_o == !e_ok, "R7/R8", {tag, " verdict fail"}, int'(fail_o), int'(!e_ok));
    chk(rd_k == e_reads, "R8", {tag, " read count"}, rd_k, e_reads);
    chk(int'(set_level_o) == e_lvl, "R5", {tag, " final level"}, int'(set_level_o), e_lvl);
    chk(!busy_o, "R6", {tag, " idle at end"}, int'(busy_o), 0);
    repeat (3) @(negedge clk);
    chk((done_o == e_ok) && (fail_o == !e_ok), "R6", {tag, " verdict held"},
        int'(done_o), int'(e_ok));
  endtask

  task automatic set_noise(int v);
    for (int i = 0; i < 128; i++) noise[i] = v;
  endtask

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h5eed_1234);
    set_noise(0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy_o && !done_o && !fail_o, "R10", "status after reset", int'(busy_o), 0);
    chk(!pulse_reset_o && !pulse_set_o && !read_req_o, "R10", "commands after reset",
        int'(pulse_reset_o) + int'(pulse_set_o) + int'(read_req_o), 0);
    chk(set_level_o == '0, "R10", "level after reset", int'(set_level_o), 0);

    // Immediate convergence in both phases.
    base = 400; slope = 10; set_noise(0);
    run_case("R6 quick", 400, 8, 8, 0);

    // Top compliance level reached without convergence.
    base = 0; slope = 0; set_noise(0);
    run_case("R7 top", 500, 63, 8, 0);

    // Exact tolerance boundaries, both signs of the difference (R3).
    base = 100; slope = 0; set_noise(0);
    noise[0] = 30; noise[1] = -29; noise[2] = 10; noise[3] = -9;
    run_case("R3 edge", 100, 10, 10, 0);

    // Fine budget exhausted, start injected while busy (R9).
    base = 200; slope = 0; set_noise(50);
    run_case("R9 inject", 200, 6, 5, 1);

    // Zero budgets behave as one iteration.
    base = 0; slope = 0; set_noise(0);
    run_case("R8 cmax0", 300, 0, 4, 0);
    base = 200; slope = 0; set_noise(50);
    run_case("R8 fmax0", 200, 4, 0, 0);

    // Constrained random runs.
    for (int r = 0; r < 40; r++) begin
      int tgt, amp;
      tgt = $urandom_range(100, 900);
      base = $urandom_range(0, 150);
      slope = $urandom_range(10, 70);
      amp = tgt / 6;
      for (int i = 0; i < 128; i++) noise[i] = int'($urandom_range(0, 2 * amp)) - amp;
      run_case("rand", tgt, $urandom_range(3, 15), $urandom_range(2, 20), 0);
    end

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule